// File: doc/BRIEF.md
# Packet-Atomic Read-Back FIFO

This block buffers configuration read-back data on its way to a processor. Read-back words arrive in packets of four 32-bit words, each presented for one cycle with a valid strobe, and they leave one word per bus read access. Each packet is committed as a unit. If there is room for all four words, all four are written in the same cycle. If there is not, the whole packet is discarded and a sticky overflow flag is raised. The packet source is never stalled.

The bus side is a single read window. A read access pops the oldest word, and that word appears on the read data output in the cycle after the access. A read of an empty FIFO returns zero and leaves the FIFO unchanged. A write access to the window is accepted but has no effect. Reset empties the FIFO and clears the flag. The depth must be a power of two.

Top module: `readback_fifo`

## Requirements
- R1: The FIFO holds DEPTH words (default 2048). With DEPTH words stored, the occupancy never goes above DEPTH.
- R2: A packet offered while at least PKT_WORDS entries are free is stored whole. Word 0 is taken from `pkt_data[31:0]`, word 1 from `pkt_data[63:32]`, and so on. The words are popped in that order, word 0 first.
- R3: A packet offered while fewer than PKT_WORDS entries are free is dropped whole. None of its words is ever read back.
- R4: A dropped packet sets `overflow`. The flag stays set until reset, whatever else happens.
- R5: A read access (`bus_sel`=1, `bus_we`=0) pops the oldest word. That word is on `rd_data` in the cycle after the access.
- R6: A read access to an empty FIFO puts 0 on `rd_data` in the next cycle and removes nothing.
- R7: A write access (`bus_sel`=1, `bus_we`=1) changes neither the stored contents nor `rd_data`.
- R8: Reset empties the FIFO and drives `rd_data` and `overflow` to 0.
- R9: When a packet and a read access arrive in the same cycle, the room check uses the occupancy before that cycle's pop. A full FIFO drops the packet even though a word leaves in that cycle, and a FIFO with exactly PKT_WORDS free entries accepts it.
- R10: `rd_data` holds its value in every cycle that has no read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_valid | input | 1 | A read-back packet is offered this cycle |
| pkt_data | input | PKT_WORDS*WORD_W | Packet words, word 0 in the lowest bits |
| bus_sel | input | 1 | Bus access to the read window this cycle |
| bus_we | input | 1 | Access direction: 1 is a write (ignored), 0 is a read |
| rd_data | output | WORD_W | Word returned by the most recent read access |
| overflow | output | 1 | Sticky flag: at least one packet was dropped |

## Verification
The bench builds the FIFO with DEPTH=16 and the default word and packet sizes. At that depth four packets fill the FIFO, so a run reaches a full FIFO, a full FIFO with one word freed, and a FIFO with exactly four free entries within a few dozen cycles. The R3 and R9 boundaries are hit exactly, and a complete drain confirms that no word of a dropped packet was stored. The same pointer wrap logic that serves 2048 entries is exercised several times per run.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
    localparam int unsigned RBF_WORD_W    = 32;
    localparam int unsigned RBF_PKT_WORDS = 4;
    localparam int unsigned RBF_DEPTH     = 2048;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/rbf_bus_decode.sv
module rbf_bus_decode
    import rbf_pkg::*;
(
    input  logic bus_sel,
    input  logic bus_we,
    output acc_e acc
);
    always_comb begin
        if (!bus_sel)    acc = ACC_NONE;
        else if (bus_we) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end
endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned PKT_WORDS = 4,
    parameter int unsigned DEPTH     = 2048,
    localparam int unsigned AW       = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [AW-1:0]                 wr_base,
    input  logic [PKT_WORDS*WORD_W-1:0]   wdata,
    input  logic [AW-1:0]                 rd_addr,
    output logic [WORD_W-1:0]             rdata
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     waddr [PKT_WORDS];

    // One write address per packet word; the sum wraps at DEPTH.
    for (genvar g = 0; g < PKT_WORDS; g++) begin : g_addr
        assign waddr[g] = wr_base + AW'(g);
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < PKT_WORDS; i++) begin
                mem[waddr[i]] <= wdata[i*WORD_W +: WORD_W];
            end
        end
    end

    assign rdata = mem[rd_addr];
endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
    import rbf_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned PKT_WORDS = 4,
    parameter int unsigned DEPTH     = 2048,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  acc_e              acc,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              push,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ptr,
    output logic [CW-1:0]     level,
    output logic [WORD_W-1:0] rd_data,
    output logic              overflow
);
    localparam logic [CW-1:0] ACCEPT_MAX = CW'(DEPTH - PKT_WORDS);
    localparam logic [CW-1:0] PKT_INC    = CW'(PKT_WORDS);

    typedef struct packed {
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic              ovf;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;
    logic   pop;

    always_comb begin
        st_d = st_q;
        // Room check on the occupancy before this cycle's pop.
        push = pkt_valid && (st_q.count <= ACCEPT_MAX);
        pop  = (acc == ACC_READ) && (st_q.count != '0);

        if (push) st_d.wr_ptr = st_q.wr_ptr + AW'(PKT_WORDS);
        if (pkt_valid && !push) st_d.ovf = 1'b1;

        if (acc == ACC_READ) begin
            st_d.rdata = pop ? mem_rdata : '0;
        end
        if (pop) st_d.rd_ptr = st_q.rd_ptr + AW'(1);

        st_d.count = st_q.count + (push ? PKT_INC : '0) - (pop ? CW'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr   = st_q.wr_ptr;
    assign rd_ptr   = st_q.rd_ptr;
    assign level    = st_q.count;
    assign rd_data  = st_q.rdata;
    assign overflow = st_q.ovf;
endmodule

// File: rtl/readback_fifo.sv
module readback_fifo
    import rbf_pkg::*;
#(
    parameter int unsigned WORD_W    = RBF_WORD_W,
    parameter int unsigned PKT_WORDS = RBF_PKT_WORDS,
    parameter int unsigned DEPTH     = RBF_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pkt_valid,
    input  logic [PKT_WORDS*WORD_W-1:0] pkt_data,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        overflow
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    acc_e              acc;
    logic              push;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     level;
    logic [WORD_W-1:0] mem_rdata;

    rbf_bus_decode u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .acc     (acc)
    );

    rbf_store #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we      (push),
        .wr_base (wr_ptr),
        .wdata   (pkt_data),
        .rd_addr (rd_ptr),
        .rdata   (mem_rdata)
    );

    rbf_ctrl #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .acc       (acc),
        .mem_rdata (mem_rdata),
        .push      (push),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .level     (level),
        .rd_data   (rd_data),
        .overflow  (overflow)
    );
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned PKT_WORDS = 4,
    parameter int unsigned DEPTH     = 2048,
    localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_valid,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [WORD_W-1:0] rd_data,
    input logic              overflow,
    input logic [CW-1:0]     level
);
    localparam logic [CW-1:0] ACCEPT_MAX = CW'(DEPTH - PKT_WORDS);
    localparam logic [CW-1:0] FULL_LVL   = CW'(DEPTH);

    logic rd_acc, wr_acc, no_room;
    assign rd_acc  = bus_sel && !bus_we;
    assign wr_acc  = bus_sel && bus_we;
    assign no_room = level > ACCEPT_MAX;

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    p_drop_holds_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && no_room && !rd_acc) |=> $stable(level));

    p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && no_room) |=> overflow);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && level == '0) |=> (rd_data == '0));

    p_write_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !pkt_valid) |=> ($stable(level) && $stable(rd_data)));

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(rd_data));
endmodule

bind readback_fifo rbf_checker #(
    .WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .rd_data   (rd_data),
    .overflow  (overflow),
    .level     (level)
);

// File: tb/readback_fifo_test.sv
`timescale 1ns/1ps
module readback_fifo_test;
    localparam int unsigned W  = 32;
    localparam int unsigned PW = 4;
    localparam int unsigned D  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_valid = 1'b0;
    logic [PW*W-1:0] pkt_data = '0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [W-1:0]    rd_data;
    logic            overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    readback_fifo #(.WORD_W(W), .PKT_WORDS(PW), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .bus_sel(bus_sel), .bus_we(bus_we), .rd_data(rd_data), .overflow(overflow)
    );

    typedef enum logic [1:0] {OP_PUSH = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;
    typedef struct packed {
        op_e         op;
        logic [31:0] base;
        logic [31:0] exp_rd;
        logic        exp_ovf;
        logic [7:0]  req;
    } vec_t;

    // Walk with DEPTH=16: R2 ordering, R5 pops, R6 empty, R7 writes,
    // R1/R3/R4 full and drop, R10 hold between reads.
    localparam int NV = 36;
    localparam vec_t TABLE [NV] = '{
        '{OP_PUSH,  32'h100, 32'h0,   1'b0, 8'd2},
        '{OP_READ,  32'h0,   32'h100, 1'b0, 8'd5},
        '{OP_READ,  32'h0,   32'h101, 1'b0, 8'd2},
        '{OP_WRITE, 32'hdead,32'h101, 1'b0, 8'd7},
        '{OP_READ,  32'h0,   32'h102, 1'b0, 8'd2},
        '{OP_READ,  32'h0,   32'h103, 1'b0, 8'd2},
        '{OP_READ,  32'h0,   32'h0,   1'b0, 8'd6},
        '{OP_PUSH,  32'h200, 32'h0,   1'b0, 8'd10},
        '{OP_PUSH,  32'h210, 32'h0,   1'b0, 8'd10},
        '{OP_PUSH,  32'h220, 32'h0,   1'b0, 8'd10},
        '{OP_PUSH,  32'h230, 32'h0,   1'b0, 8'd1},
        '{OP_PUSH,  32'h240, 32'h0,   1'b1, 8'd3},
        '{OP_READ,  32'h0,   32'h200, 1'b1, 8'd4},
        '{OP_PUSH,  32'h250, 32'h200, 1'b1, 8'd3},
        '{OP_READ,  32'h0,   32'h201, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h202, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h203, 1'b1, 8'd5},
        '{OP_PUSH,  32'h260, 32'h203, 1'b1, 8'd2},
        '{OP_READ,  32'h0,   32'h210, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h211, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h212, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h213, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h220, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h221, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h222, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h223, 1'b1, 8'd5},
        '{OP_READ,  32'h0,   32'h230, 1'b1, 8'd1},
        '{OP_READ,  32'h0,   32'h231, 1'b1, 8'd1},
        '{OP_READ,  32'h0,   32'h232, 1'b1, 8'd1},
        '{OP_READ,  32'h0,   32'h233, 1'b1, 8'd1},
        '{OP_READ,  32'h0,   32'h260, 1'b1, 8'd2},
        '{OP_READ,  32'h0,   32'h261, 1'b1, 8'd2},
        '{OP_READ,  32'h0,   32'h262, 1'b1, 8'd2},
        '{OP_READ,  32'h0,   32'h263, 1'b1, 8'd2},
        '{OP_READ,  32'h0,   32'h0,   1'b1, 8'd3},
        '{OP_WRITE, 32'hbeef,32'h0,   1'b1, 8'd7}
    };

    function automatic logic [PW*W-1:0] mk_pkt(input logic [31:0] base);
        logic [PW*W-1:0] p;
        for (int i = 0; i < PW; i++) p[i*W +: W] = base + 32'(i);
        return p;
    endfunction

    // Drive one cycle of stimulus at a falling edge, then release it.
    // The design registers it on the next rising edge; checks follow at the
    // falling edge after that.
    task automatic cycle(input bit push, input bit rd, input bit wr, input logic [31:0] base);
        @(negedge clk);
        pkt_valid = push;
        pkt_data  = push ? mk_pkt(base) : '0;
        bus_sel   = rd || wr;
        bus_we    = wr;
        @(negedge clk);
        pkt_valid = 1'b0;
        pkt_data  = '0;
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "rd_data after reset", rd_data, 32'h0);
        check("R8", "overflow after reset", {31'h0, overflow}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            cycle(TABLE[v].op == OP_PUSH, TABLE[v].op == OP_READ,
                  TABLE[v].op == OP_WRITE, TABLE[v].base);
            check($sformatf("R%0d", TABLE[v].req), $sformatf("row %0d rd_data", v),
                  rd_data, TABLE[v].exp_rd);
            check($sformatf("R%0d", TABLE[v].req), $sformatf("row %0d overflow", v),
                  {31'h0, overflow}, {31'h0, TABLE[v].exp_ovf});
        end

        // R8: reset with data stored and the flag set.
        cycle(1'b1, 1'b0, 1'b0, 32'h300);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R8", "rd_data after mid-run reset", rd_data, 32'h0);
        check("R8", "overflow cleared by reset", {31'h0, overflow}, 32'h0);
        cycle(1'b0, 1'b1, 1'b0, 32'h0);
        check("R8", "FIFO empty after reset", rd_data, 32'h0);

        // R9: exactly four free entries, push and pop together -> accepted.
        cycle(1'b1, 1'b0, 1'b0, 32'h400);
        cycle(1'b1, 1'b0, 1'b0, 32'h410);
        cycle(1'b1, 1'b0, 1'b0, 32'h420);
        cycle(1'b1, 1'b1, 1'b0, 32'h430);
        check("R9", "pop with push at 12 words", rd_data, 32'h400);
        check("R9", "no drop at 12 words", {31'h0, overflow}, 32'h0);
        for (int k = 1; k < 16; k++) begin
            exp = 32'h400 + 32'((k / 4) * 16) + 32'(k % 4);
            cycle(1'b0, 1'b1, 1'b0, 32'h0);
            check("R9", "drain after accepted push", rd_data, exp);
        end
        cycle(1'b0, 1'b1, 1'b0, 32'h0);
        check("R6", "empty after drain", rd_data, 32'h0);

        // R9: full FIFO, push and pop together -> dropped.
        cycle(1'b1, 1'b0, 1'b0, 32'h500);
        cycle(1'b1, 1'b0, 1'b0, 32'h510);
        cycle(1'b1, 1'b0, 1'b0, 32'h520);
        cycle(1'b1, 1'b0, 1'b0, 32'h530);
        cycle(1'b1, 1'b1, 1'b0, 32'h540);
        check("R9", "pop with push when full", rd_data, 32'h500);
        check("R9", "drop when full despite pop", {31'h0, overflow}, 32'h1);
        for (int k = 1; k < 16; k++) begin
            exp = 32'h500 + 32'((k / 4) * 16) + 32'(k % 4);
            cycle(1'b0, 1'b1, 1'b0, 32'h0);
            check("R3", "drain after dropped push", rd_data, exp);
        end
        cycle(1'b0, 1'b1, 1'b0, 32'h0);
        check("R3", "dropped packet never stored", rd_data, 32'h0);
        check("R4", "flag still set", {31'h0, overflow}, 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule